// File: doc/BRIEF.md
# Coprocessor Escape Decode and Trap

This block is a front-end decode stage for a processor that hands floating-point work to an optional external coprocessor. It takes opcode bytes one at a time through a valid/ready handshake and sorts each one into one of three classes. An escape byte (D8h to DFh) always takes a second byte, the ModR/M byte, as part of the same instruction. The synchronising WAIT opcode (9Bh) is a single byte. Every other byte is a single-byte ordinary instruction, and this block has no further interest in it.

What happens to an escape depends on three things. The first is the emulate bit of a 16-bit machine status word, which is held inside the block and loaded through a simple write port. The second is a presence input for the coprocessor, and the third is the coprocessor's busy line. If emulation is on, the escape is turned into a fault request with vector 7. If a coprocessor is fitted, the escape is forwarded to it together with a memory-operand request when the ModR/M byte names memory. If no coprocessor is fitted, the escape completes silently.

WAIT stalls the stream while busy is high. An absent coprocessor presents busy as permanently high, so a WAIT hangs in that case. Escapes that wait are held while the coprocessor is busy. The non-waiting control forms (initialise, clear exceptions, store status, store control word) are never held.

Top module: `esc_decode`

## Requirements
- R1: After reset `msw_o` is 0, `cop_strobe_o`, `mem_req_o` and `fault_o` are low, and the block is ready for an opcode byte that is not 9Bh.
- R2: Bytes D8h..DFh are escapes, and the next accepted byte is taken as their ModR/M byte. Any other byte except 9Bh is a one-byte instruction and produces no strobe, memory request or fault. Accepting an escape opcode byte alone produces none of these either.
- R3: With emulation off and `cop_present_i` high, accepting the ModR/M byte gives a one-cycle `cop_strobe_o` in the next cycle. In that cycle `cop_op_o` = {escape opcode bits 2:0, ModR/M byte}.
- R4: A forwarded escape whose ModR/M bits 7:6 are not 11b raises `mem_req_o` in the same cycle as the strobe. With 11b (register form), `mem_req_o` stays low.
- R5: When bit 2 (emulate) of the status word is set, an escape gives a one-cycle `fault_o` with `fault_vec_o` = 7 after its ModR/M byte. There is no strobe and no memory request, and `busy` is not waited on.
- R6: A cycle with `msw_wr_i` high loads all 16 bits of `msw_data_i`, and `msw_o` shows them from the next cycle.
- R7: With emulation off and `cop_present_i` low, an escape is accepted without stalling even while busy is high, and it gives no strobe, memory request or fault.
- R8: WAIT (9Bh) is held with `byte_ready_o` low while `cop_busy_i` is high, and it is accepted in a cycle where busy is low. With an absent coprocessor (busy held high) it never completes.
- R9: With a coprocessor present, emulation off and busy high, the ModR/M byte of a waiting escape is held until busy falls, and the strobe follows its acceptance.
- R10: The non-waiting forms are never held by busy. They are DBh with E2h or E3h, DFh with E0h, DDh with a memory ModR/M whose bits 5:3 are 7, and D9h with a memory ModR/M whose bits 5:3 are 6 or 7.
- R11: `stall_o` is high exactly when `byte_valid_i` is high and `byte_ready_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| byte_i | input | 8 | Opcode or ModR/M byte |
| byte_valid_i | input | 1 | Byte valid |
| byte_ready_o | output | 1 | Byte accepted this cycle when valid |
| stall_o | output | 1 | Valid byte held back |
| msw_wr_i | input | 1 | Status word load strobe |
| msw_data_i | input | MSW_W | Status word load value |
| msw_o | output | MSW_W | Status word contents |
| cop_present_i | input | 1 | Coprocessor fitted |
| cop_busy_i | input | 1 | Coprocessor busy |
| cop_strobe_o | output | 1 | Escape forwarded to coprocessor |
| cop_op_o | output | 11 | Escape opcode bits and ModR/M byte |
| mem_req_o | output | 1 | Memory operand transfer request |
| fault_o | output | 1 | Fault request |
| fault_vec_o | output | VEC_W | Fault vector |

## Verification
The bench builds the block with its default parameters: a 16-bit status word with emulate at bit 2, an 8-bit vector and fault vector 7. These defaults let the status-word loads toggle the trap bit and let the bench compare the vector against 7. Random streams mix escapes with random ModR/M bytes, WAITs and ordinary bytes. They run under random emulate and presence settings, and an absent coprocessor is modelled with busy high. Directed cases hold busy high against waiting escapes, the non-waiting forms and WAIT, including a WAIT that hangs on an absent coprocessor.

// File: rtl/esc_pkg.sv
`timescale 1ns/1ps
package esc_pkg;
  localparam logic [7:0] WAIT_OPC = 8'h9B;

  typedef enum logic {ST_OPC, ST_MODRM} dec_state_e;

  typedef struct packed {
    logic [2:0] opc;
    logic [7:0] modrm;
  } cop_word_t;

  function automatic logic is_esc(input logic [7:0] b);
    return b[7:3] == 5'b11011;
  endfunction

  // forms that must never wait on busy
  function automatic logic no_wait_form(input logic [2:0] opc, input logic [7:0] modrm);
    logic mem_f;
    logic [2:0] sub;
    logic r;
    mem_f = (modrm[7:6] != 2'b11);
    sub   = modrm[5:3];
    case (opc)
      3'd3:    r = (modrm == 8'hE2) || (modrm == 8'hE3);
      3'd7:    r = (modrm == 8'hE0);
      3'd5:    r = mem_f && (sub == 3'd7);
      3'd1:    r = mem_f && (sub == 3'd6 || sub == 3'd7);
      default: r = 1'b0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/esc_msw_reg.sv
`timescale 1ns/1ps
module esc_msw_reg #(
  parameter int MSW_W  = 16,
  parameter int EM_BIT = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [MSW_W-1:0] data_i,
  output logic [MSW_W-1:0] msw_o,
  output logic             em_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   msw_o <= '0;
    else if (wr_i) msw_o <= data_i;
  end

  assign em_o = msw_o[EM_BIT];

  // R6
  msw_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> msw_o == $past(data_i));
endmodule

// File: rtl/esc_gate.sv
`timescale 1ns/1ps
module esc_gate
  import esc_pkg::*;
(
  input  dec_state_e state_i,
  input  logic [2:0] opc_i,
  input  logic [7:0] byte_i,
  input  logic       valid_i,
  input  logic       em_i,
  input  logic       present_i,
  input  logic       busy_i,
  output logic       ready_o,
  output logic       stall_o
);
  always_comb begin
    if (state_i == ST_MODRM)
      ready_o = em_i | ~present_i | ~busy_i | no_wait_form(opc_i, byte_i);
    else
      ready_o = ~((byte_i == WAIT_OPC) & busy_i);
    stall_o = valid_i & ~ready_o;
  end
endmodule

// File: rtl/esc_seq.sv
`timescale 1ns/1ps
module esc_seq
  import esc_pkg::*;
#(
  parameter int VEC_W     = 8,
  parameter int FAULT_VEC = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       byte_i,
  input  logic             valid_i,
  input  logic             ready_i,
  input  logic             em_i,
  input  logic             present_i,
  input  logic             busy_i,
  output dec_state_e       state_o,
  output logic [2:0]       opc_o,
  output logic             strobe_o,
  output cop_word_t        cop_o,
  output logic             mem_req_o,
  output logic             fault_o,
  output logic [VEC_W-1:0] vec_o
);
  localparam logic [VEC_W-1:0] VEC = VEC_W'(FAULT_VEC);

  logic accept, fire, fwd;

  assign accept = valid_i & ready_i;
  assign fire   = accept & (state_o == ST_MODRM);
  assign fwd    = fire & ~em_i & present_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o   <= ST_OPC;
      opc_o     <= '0;
      strobe_o  <= 1'b0;
      cop_o     <= '0;
      mem_req_o <= 1'b0;
      fault_o   <= 1'b0;
      vec_o     <= '0;
    end else begin
      if (accept) begin
        if (state_o == ST_OPC && is_esc(byte_i)) begin
          state_o <= ST_MODRM;
          opc_o   <= byte_i[2:0];
        end else begin
          state_o <= ST_OPC;
        end
      end
      strobe_o  <= fwd;
      mem_req_o <= fwd & (byte_i[7:6] != 2'b11);
      fault_o   <= fire & em_i;
      vec_o     <= (fire & em_i) ? VEC : '0;
      if (fire) cop_o <= '{opc: opc_o, modrm: byte_i};
    end
  end

  // R5
  fault_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> !strobe_o && !mem_req_o);
  // R5
  fault_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> vec_o == VEC);
  // R4
  mem_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> strobe_o);
  // R3
  strobe_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |=> !strobe_o);
  // R8
  wait_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && state_o == ST_OPC && byte_i == WAIT_OPC) |-> !busy_i);
  // R7
  absent_flow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && state_o == ST_MODRM && !present_i) |-> ready_i);
  // R9
  esc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && present_i && !em_i && !no_wait_form(opc_o, byte_i)) |-> !busy_i);
endmodule

// File: rtl/esc_decode.sv
`timescale 1ns/1ps
module esc_decode
  import esc_pkg::*;
#(
  parameter int MSW_W     = 16,
  parameter int EM_BIT    = 2,
  parameter int VEC_W     = 8,
  parameter int FAULT_VEC = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       byte_i,
  input  logic             byte_valid_i,
  output logic             byte_ready_o,
  output logic             stall_o,
  input  logic             msw_wr_i,
  input  logic [MSW_W-1:0] msw_data_i,
  output logic [MSW_W-1:0] msw_o,
  input  logic             cop_present_i,
  input  logic             cop_busy_i,
  output logic             cop_strobe_o,
  output logic [10:0]      cop_op_o,
  output logic             mem_req_o,
  output logic             fault_o,
  output logic [VEC_W-1:0] fault_vec_o
);
  logic       em;
  dec_state_e state;
  logic [2:0] opc;
  cop_word_t  cop_w;

  esc_msw_reg #(.MSW_W(MSW_W), .EM_BIT(EM_BIT)) u_msw (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(msw_wr_i), .data_i(msw_data_i),
    .msw_o(msw_o), .em_o(em)
  );

  esc_gate u_gate (
    .state_i(state), .opc_i(opc), .byte_i(byte_i), .valid_i(byte_valid_i),
    .em_i(em), .present_i(cop_present_i), .busy_i(cop_busy_i),
    .ready_o(byte_ready_o), .stall_o(stall_o)
  );

  esc_seq #(.VEC_W(VEC_W), .FAULT_VEC(FAULT_VEC)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .byte_i(byte_i), .valid_i(byte_valid_i),
    .ready_i(byte_ready_o), .em_i(em), .present_i(cop_present_i),
    .busy_i(cop_busy_i), .state_o(state), .opc_o(opc), .strobe_o(cop_strobe_o),
    .cop_o(cop_w), .mem_req_o(mem_req_o), .fault_o(fault_o), .vec_o(fault_vec_o)
  );

  assign cop_op_o = cop_w;

  // R11
  stall_def_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> byte_valid_i && !byte_ready_o);
endmodule

// File: tb/esc_decode_tb_top.sv
`timescale 1ns/1ps
module esc_decode_tb_top;
  logic        clk = 0, rst_n = 0;
  logic [7:0]  byt = 0;
  logic        valid = 0, msw_wr = 0, present = 0, busy = 0;
  logic [15:0] msw_d = 0;
  logic        ready, stall, strobe, mem_req, fault;
  logic [10:0] cop_op;
  logic [15:0] msw;
  logic [7:0]  vec;
  int n_chk = 0, n_fail = 0;
  bit em_m = 0;

  always #10 clk = ~clk;

  esc_decode dut_i (
    .clk_i(clk), .rst_ni(rst_n), .byte_i(byt), .byte_valid_i(valid),
    .byte_ready_o(ready), .stall_o(stall), .msw_wr_i(msw_wr), .msw_data_i(msw_d),
    .msw_o(msw), .cop_present_i(present), .cop_busy_i(busy),
    .cop_strobe_o(strobe), .cop_op_o(cop_op), .mem_req_o(mem_req),
    .fault_o(fault), .fault_vec_o(vec)
  );

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: act=expired exp=done");
    finish_run();
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic bit is_esc_m(input logic [7:0] b);
    return b >= 8'hD8 && b <= 8'hDF;
  endfunction

  // send one byte, return stall cycles; checks at the negedge after acceptance
  task automatic send(input logic [7:0] b, output int waited);
    waited = 0;
    @(negedge clk); valid = 1; byt = b;
    #1;
    while (!ready) begin
      @(negedge clk); #1;
      waited++;
    end
    @(posedge clk);
    @(negedge clk); valid = 0;
  endtask

  task automatic load_msw(input logic [15:0] d);
    @(negedge clk); msw_wr = 1; msw_d = d;
    @(negedge clk); msw_wr = 0;
    chk("R6 msw load", msw, d);
    em_m = d[2];
  endtask

  task automatic do_esc(input logic [7:0] op, input logic [7:0] m, input string tag);
    int w;
    bit fwd;
    send(op, w);
    chk({tag, " R2 opcode byte quiet"}, {strobe, fault, mem_req}, 3'b000);
    send(m, w);
    fwd = !em_m && present;
    chk({tag, " R3 strobe"}, strobe, fwd);
    if (fwd) chk({tag, " R3 cop_op"}, cop_op, {op[2:0], m});
    chk({tag, " R4 mem_req"}, mem_req, fwd && m[7:6] != 2'b11);
    chk({tag, " R5 fault"}, fault, em_m);
    chk({tag, " R5 vec"}, vec, em_m ? 8'd7 : 8'd0);
    if (!present && !em_m) chk({tag, " R7 no stall"}, w, 0);
  endtask

  initial begin
    int w;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    #1;
    chk("R1 msw", msw, 16'h0);
    chk("R1 outputs", {strobe, fault, mem_req}, 3'b000);
    chk("R1 ready", ready, 1'b1);
    rst_n = 1;

    // R3 R4 forwarded register and memory forms
    present = 1; busy = 0;
    do_esc(8'hD8, 8'hC1, "dir reg");
    do_esc(8'hDC, 8'h46, "dir mem");
    // R2 ordinary bytes
    send(8'h90, w); chk("R2 plain", {strobe, fault, mem_req}, 3'b000);
    send(8'hD7, w); chk("R2 below range", {strobe, fault, mem_req}, 3'b000);
    send(8'hE0, w); chk("R2 above range", {strobe, fault, mem_req}, 3'b000);

    // R5 emulation trap, busy ignored
    load_msw(16'hA5A4);
    busy = 1;
    do_esc(8'hD9, 8'h06, "trap");
    chk("R5 msw kept", msw, 16'hA5A4);
    load_msw(16'h0000);

    // R9 waiting escape held
    send(8'hDE, w);
    @(negedge clk); valid = 1; byt = 8'hC9;
    for (int i = 0; i < 5; i++) begin
      #1; chk("R9 held", ready, 1'b0); chk("R11 stall", stall, 1'b1);
      chk("R9 no strobe", strobe, 1'b0);
      @(negedge clk);
    end
    busy = 0; #1;
    chk("R9 released", ready, 1'b1);
    @(posedge clk); @(negedge clk); valid = 0;
    chk("R9 strobe", strobe, 1'b1);
    chk("R9 cop_op", cop_op, {3'd6, 8'hC9});

    // R10 non-waiting forms under busy
    busy = 1;
    do_esc(8'hDB, 8'hE3, "R10 init"); 
    do_esc(8'hDB, 8'hE2, "R10 clex");
    do_esc(8'hDF, 8'hE0, "R10 stsw ax");
    do_esc(8'hDD, 8'h3E, "R10 stsw mem");
    do_esc(8'hD9, 8'h7E, "R10 stcw mem");

    // R8 WAIT stalls while busy
    @(negedge clk); valid = 1; byt = 8'h9B;
    for (int i = 0; i < 4; i++) begin
      #1; chk("R8 wait held", ready, 1'b0); chk("R11 stall", stall, 1'b1);
      @(negedge clk);
    end
    busy = 0; #1;
    chk("R8 wait go", ready, 1'b1);
    @(posedge clk); @(negedge clk); valid = 0; #1;
    chk("R11 idle", stall, 1'b0);

    // R7 absent: busy high forever, escapes flow, WAIT hangs
    present = 0; busy = 1;
    do_esc(8'hD8, 8'hC1, "R7 absent reg");
    do_esc(8'hDD, 8'h16, "R7 absent mem");
    @(negedge clk); valid = 1; byt = 8'h9B;
    for (int i = 0; i < 20; i++) begin
      #1; chk("R8 absent wait hangs", ready, 1'b0);
      @(negedge clk);
    end
    valid = 0;

    // random mix
    for (int it = 0; it < 400; it++) begin
      int k;
      logic [7:0] b;
      if ($urandom % 8 == 0) load_msw(16'($urandom) & 16'hFFFF);
      present = $urandom % 2;
      busy = !present;
      k = $urandom % 4;
      if (k < 2) begin
        do_esc(8'hD8 | 8'($urandom % 8), 8'($urandom), "rnd");
      end else if (k == 2 && present) begin
        send(8'h9B, w); chk("R8 rnd wait", w, 0);
      end else begin
        b = 8'($urandom);
        if (!is_esc_m(b) && b != 8'h9B) begin
          send(b, w);
          chk("R2 rnd plain", {strobe, fault, mem_req}, 3'b000);
        end
      end
    end
    finish_run();
  end
endmodule